// File: doc/BRIEF.md
# Sequential Restoring Divider

The block divides one 32-bit operand by another over a fixed number of clock cycles. It uses a single subtract path and one wide shift register. The right half of that register starts out holding the dividend. Quotient bits are pushed in at its low end while the partial remainder builds up in the upper part. A one-bit extension above the upper half keeps the partial remainder exact when the divisor has its top bit set. Because quotient and remainder share one register, the remainder ends one position too far to the left, so a final correction cycle shifts the upper part back right by one place.

A caller drives `start` for one cycle with the operands and the mode. The caller then waits for the one-cycle `done` pulse. In signed mode, the operands are converted to magnitudes before the loop, and the signs are applied to the results afterwards. Results stay on the outputs until the next operation completes.

Top module: `restoring_divider`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` sampled high while `busy` is 0 sets `busy` from the next cycle. `done` rises exactly W+1 clock edges after the accepting edge and lasts one cycle. `busy` is low while `done` is high.
- R3: With `signed_mode` = 0, `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor, as unsigned numbers.
- R4: Results are exact when the divisor is 2^(W-1) or larger. During the loop, the partial remainder stays below twice the divisor.
- R5: With `signed_mode` = 1, operands are two's complement. The quotient is truncated toward zero, and the remainder takes the sign of the dividend. The most negative value divided by -1 yields the most negative value with remainder 0.
- R6: When the divisor is 0, the operation takes the normal number of cycles and returns a quotient of all ones with `remainder` equal to the dividend, in both modes.
- R7: `start` while `busy` is 1 is ignored. The running operation completes on schedule with its own operands, and no extra `done` follows.
- R8: `quotient` and `remainder` change only in the cycle where `done` is high. Otherwise they hold their last values.
- R9: A `start` in the same cycle as `done` is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | W | Dividend operand |
| divisor | input | W | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient of the last completed operation |
| remainder | output | W | Remainder of the last completed operation |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle, because `done` is high while the block is already idle. The driver always waits only for `busy` to drop, so every operation after the first is issued in the `done` cycle of its predecessor. The scoreboard then checks two things for each operation. The pulse of the new operation must arrive exactly W+1 cycles later with its own result. The result just reported must stay unchanged through the whole new run.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic neg_quot;
        logic neg_rem;
    } sign_fix_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] num_in,
    input  logic [W-1:0] den_in,
    input  logic         use_signed,
    output logic [W-1:0] num_mag,
    output logic [W-1:0] den_mag,
    output sign_fix_t    fix
);
    logic num_neg, den_neg, den_zero;

    always_comb begin
        num_neg  = use_signed & num_in[W-1];
        den_neg  = use_signed & den_in[W-1];
        den_zero = (den_in == '0);
        num_mag  = num_neg ? (~num_in + 1'b1) : num_in;
        den_mag  = den_neg ? (~den_in + 1'b1) : den_in;
        fix.neg_rem  = num_neg;
        fix.neg_quot = (num_neg ^ den_neg) & ~den_zero;
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 32
) (
    input  logic [W:0]   part_in,
    input  logic [W-1:0] low_in,
    input  logic [W-1:0] den,
    output logic [W:0]   part_out,
    output logic [W-1:0] low_out
);
    localparam int DW = W + 2;

    logic [DW-1:0] trial;
    logic          fits;
    logic [W:0]    kept;

    always_comb begin
        trial    = {1'b0, part_in} - {2'b00, den};
        fits     = ~trial[DW-1];
        kept     = fits ? trial[W:0] : part_in;
        part_out = {kept[W-1:0], low_in[W-1]};
        low_out  = {low_in[W-2:0], fits};
    end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] quot_mag,
    input  logic [W-1:0] rem_mag,
    input  sign_fix_t    fix,
    output logic [W-1:0] quot_out,
    output logic [W-1:0] rem_out
);
    always_comb begin
        quot_out = fix.neg_quot ? (~quot_mag + 1'b1) : quot_mag;
        rem_out  = fix.neg_rem  ? (~rem_mag  + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = $clog2(W);
    localparam int BW = $clog2(W + 2) + 1;
    localparam logic [CW-1:0] LAST_ITER = CW'(W - 1);

    div_state_e     state;
    logic [CW-1:0]  iter;
    logic [W:0]     part_q;
    logic [W-1:0]   low_q;
    logic [W-1:0]   den_q;
    sign_fix_t      fix_q;

    logic [W-1:0]   a_mag, b_mag;
    sign_fix_t      fix_d;
    logic [W:0]     part_nx;
    logic [W-1:0]   low_nx;
    logic [W-1:0]   quot_fx, rem_fx;

    div_operand_prep #(.W(W)) u_prep (
        .num_in    (dividend),
        .den_in    (divisor),
        .use_signed(signed_mode),
        .num_mag   (a_mag),
        .den_mag   (b_mag),
        .fix       (fix_d)
    );

    div_step #(.W(W)) u_step (
        .part_in (part_q),
        .low_in  (low_q),
        .den     (den_q),
        .part_out(part_nx),
        .low_out (low_nx)
    );

    // correction: upper part shifted back right by one place
    div_sign_fix #(.W(W)) u_fix (
        .quot_mag(low_q),
        .rem_mag (part_q[W:1]),
        .fix     (fix_q),
        .quot_out(quot_fx),
        .rem_out (rem_fx)
    );

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            iter      <= '0;
            part_q    <= '0;
            low_q     <= '0;
            den_q     <= '0;
            fix_q     <= '0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        // load and apply the initial left shift at once
                        part_q <= {{W{1'b0}}, a_mag[W-1]};
                        low_q  <= {a_mag[W-2:0], 1'b0};
                        den_q  <= b_mag;
                        fix_q  <= fix_d;
                        iter   <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    part_q <= part_nx;
                    low_q  <= low_nx;
                    iter   <= iter + 1'b1;
                    if (iter == LAST_ITER) state <= ST_FIX;
                end
                ST_FIX: begin
                    quotient  <= quot_fx;
                    remainder <= rem_fx;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [BW-1:0] busy_len;
    always_ff @(posedge clk) begin
        if (rst) busy_len <= '0;
        else     busy_len <= busy ? busy_len + 1'b1 : '0;
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_len == BW'(W + 1)));

    assert_part_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && den_q != '0) |-> (part_q < {den_q, 1'b0}));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder)));

endmodule

// File: tb/tb_restoring_divider.sv
module tb_restoring_divider;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done;
    logic [W-1:0] quotient, remainder;

    restoring_divider #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        int           due;
        string        tag;
    } item_t;

    item_t  sb[$];
    int     cyc = 0;
    int     checks = 0;
    int     errors = 0;
    int     dones = 0;
    logic [W-1:0] last_q = '0, last_r = '0;
    bit     finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input bit s, output logic [W-1:0] q,
                                  output logic [W-1:0] r);
        longint sa, sb2;
        if (b == '0) begin
            q = '1; r = a;
        end else if (!s) begin
            q = a / b; r = a % b;
        end else begin
            sa = longint'($signed(a));
            sb2 = longint'($signed(b));
            q = W'(sa / sb2);
            r = W'(sa % sb2);
        end
    endfunction

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit s, input string tag);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        model(a, b, s, it.q, it.r);
        it.due = cyc + W + 2;
        it.tag = tag;
        sb.push_back(it);
        dividend = a; divisor = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done) begin
                dones++;
                if (sb.size() == 0) begin
                    check(0, "R7", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(quotient == it.q, it.tag, "quotient", quotient, it.q);
                    check(remainder == it.r, it.tag, "remainder", remainder, it.r);
                    check(cyc == it.due, "R2", "done cycle", cyc, it.due);
                    check(!busy, "R2", "busy during done", busy, 0);
                end
                last_q = quotient; last_r = remainder;
            end else if (quotient !== last_q || remainder !== last_r) begin
                check(0, "R8", "output changed without done", quotient, last_q);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && quotient == '0 && remainder == '0,
              "R1", "state in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && quotient == '0 && remainder == '0,
              "R1", "state after reset", quotient, 0);

        // R3 unsigned, several patterns; consecutive issues exercise R9
        issue(32'd100, 32'd7, 0, "R3");
        issue(32'hFFFF_FFFF, 32'd1, 0, "R3");
        issue(32'd5, 32'd10, 0, "R3");
        issue(32'd0, 32'd5, 0, "R3");
        issue(32'hDEAD_BEEF, 32'h0001_2345, 0, "R9");
        // R4 divisor with top bit set
        issue(32'hFFFF_FFFE, 32'h8000_0001, 0, "R4");
        issue(32'hFFFF_FFFF, 32'h8000_0000, 0, "R4");
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4");
        issue(32'h8000_0000, 32'h8000_0001, 0, "R4");
        // R5 signed
        issue(32'hFFFF_FFF9, 32'd2, 1, "R5");
        issue(32'd7, 32'hFFFF_FFFE, 1, "R5");
        issue(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1, "R5");
        issue(32'h8000_0000, 32'hFFFF_FFFF, 1, "R5");
        issue(32'd100, 32'd7, 1, "R5");
        // R6 divide by zero
        issue(32'd12345, 32'd0, 0, "R6");
        issue(32'hFFFF_FFF9, 32'd0, 1, "R6");

        // R7 start while busy is ignored
        issue(32'd1000, 32'd3, 0, "R7");
        repeat (5) @(negedge clk);
        dividend = 32'd1; divisor = 32'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (W + 8) @(negedge clk);
        check(sb.size() == 0, "R7", "pending items", sb.size(), 0);
        check(dones == 17, "R7", "done count", dones, 17);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule